// File: doc/BRIEF.md
# Flash Command Register Front End

This block is the register-level control front end of an embedded flash array. A host reaches it over a simple 32-bit register bus with one write strobe and a read path that always shows the addressed word. Through the bus the host sets a target address, a clock divisor, a control word, interrupt flags with their enables, and four data words. The control word starts one of three operations: program, page erase or whole-array erase. An operation starts only when the control word carries the correct 4-bit unlock key. Each erase also needs its own 8-bit magic code beside the request bit. A request that breaks a rule never starts. It raises the access-fault flag instead.

An accepted operation passes through a four-state sequencer. IDLE waits for an accepted request. IDLE→ISSUE is taken on acceptance. ISSUE drives a one-cycle launch toward the flash side and always moves to WAIT. WAIT runs a behavioural timing stub that counts flash ticks of the divided clock, and moves to FINISH when the required tick count is reached. FINISH lasts one cycle, sets the completion flag and returns to IDLE. The interrupt output combines each flag with its enable. Gating of the information-block access register is handled elsewhere, so that word reads as zero here.

Top module: `flcmd_top`

## Requirements
- R1: After reset every register reads 0 (the unlock field included, which counts as locked), busy is 0, `irq` is 0 and `op_start` is 0.
- R2: The word offsets are as follows. Address is at 0x00 and reads back all 32 bits. Clock divide is at 0x04 and keeps only its low 8 bits. Data words 0..3 are at 0x30, 0x34, 0x38 and 0x3C and read back as written. The access-control word at 0x40 always reads 0. Any unmapped offset reads 0.
- R3: A control write (offset 0x08) with unlock field bits 31:28 = 0x2 and start bit 0 alone launches a program. `op_start` is high for exactly one cycle, `op_kind` = 1 and `op_addr` = address register. If bit 4 = 0 the program is 128 bits wide: `op_wide` = 1 and `op_data` = {data3,data2,data1,data0}. If bit 4 = 1 it is 32 bits wide: `op_wide` = 0 and `op_data` = data0 with the upper 96 bits zero.
- R4: Under the unlock key, start bit 2 with erase code (bits 15:8) 0x55 launches a page erase (`op_kind` = 2). Start bit 1 with code 0xAA launches a whole-array erase (`op_kind` = 3). Any other code with an erase bit sets the fault flag and launches nothing.
- R5: Once an operation is accepted, control bit 24 (busy) and that operation's start bit read 1 for exactly N*K+2 cycles. N is the clock-divide value, with 0 treated as 1. K is 2 for program, 3 for page erase and 5 for whole-array erase. After that both read 0.
- R6: A start request whose unlock field is not 0x2 launches nothing and sets the fault flag (interrupt register bit 1).
- R7: While busy, a start request launches nothing and sets the fault flag. Writes to the address, clock-divide, control and data words are ignored while busy.
- R8: A 128-bit program whose address has bits 3:0 non-zero sets the fault flag and launches nothing. A 32-bit program has no alignment rule.
- R9: A control write with more than one of start bits 0..2 set sets the fault flag and launches nothing. A control write with none of them set launches nothing and sets no flag.
- R10: Writing the interrupt register (offset 0x24) clears each flag (bit 0 done, bit 1 fault) where the written bit is 0 and keeps it where the written bit is 1. Bits 8 and 9 of the same write set the done and fault enables.
- R11: `irq` is 1 exactly when (done AND enable 8) OR (fault AND enable 9).
- R12: The done flag is set in the same cycle that busy falls at the end of an accepted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 7 | Byte offset of the register word |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Contents of the addressed word |
| irq | output | 1 | Interrupt request |
| op_start | output | 1 | One-cycle launch of a flash operation |
| op_kind | output | 2 | Operation in progress: 0 none, 1 program, 2 page erase, 3 whole-array erase |
| op_addr | output | 32 | Target address |
| op_wide | output | 1 | 1 for a 128-bit program, 0 for 32-bit |
| op_data | output | 128 | Program data |

## Verification
The assertions assume a host that issues at most one write per cycle and never drives the bus with unknown values after reset. They also assume that the clock divisor and the tick counts stay small enough for an operation to end. The stimulus keeps the divisor between 0 and 4. It always issues single-cycle writes on the falling clock edge. It waits for busy to drop before it begins the next random operation. The overlapping-start case is the only time a request is issued while busy, and it is issued on purpose.

// File: rtl/flcmd_pkg.sv
package flcmd_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PROG = 2'd1,
        OP_PAGE = 2'd2,
        OP_MASS = 2'd3
    } op_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_WAIT   = 2'd2,
        ST_FINISH = 2'd3
    } seq_state_t;

    localparam int OFF_ADDR   = 'h00;
    localparam int OFF_CLKDIV = 'h04;
    localparam int OFF_CTRL   = 'h08;
    localparam int OFF_INTR   = 'h24;
    localparam int OFF_DATA0  = 'h30;
    localparam int OFF_ACCESS = 'h40;

    localparam logic [3:0] KEY_OPEN  = 4'h2;
    localparam logic [7:0] CODE_PAGE = 8'h55;
    localparam logic [7:0] CODE_MASS = 8'hAA;

endpackage

// File: rtl/flcmd_timer.sv
module flcmd_timer #(
    parameter int DIV_W  = 8,
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [DIV_W-1:0]  divisor,
    input  logic [TICK_W-1:0] ticks,
    output logic              expire
);

    logic [DIV_W-1:0]  div_cnt;
    logic [DIV_W-1:0]  div_lim;
    logic [TICK_W-1:0] tick_cnt;
    logic              tick;

    // A divisor of zero behaves as one.
    assign div_lim = (divisor == '0) ? '0 : divisor - 1'b1;
    assign tick    = run && (div_cnt == div_lim);
    assign expire  = tick && (tick_cnt == ticks - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_cnt  <= '0;
            tick_cnt <= '0;
        end else if (tick) begin
            div_cnt  <= '0;
            tick_cnt <= tick_cnt + 1'b1;
        end else begin
            div_cnt  <= div_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/flcmd_seq.sv
module flcmd_seq
    import flcmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept,
    input  op_kind_t   req_kind,
    input  logic       expire,
    output seq_state_t state,
    output op_kind_t   cur_kind,
    output logic       busy,
    output logic       op_start,
    output logic       run,
    output logic       finish
);

    seq_state_t nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                 cur_kind <= OP_NONE;
        else if (accept)            cur_kind <= req_kind;
        else if (state == ST_FINISH) cur_kind <= OP_NONE;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (accept) nxt = ST_ISSUE;
            ST_ISSUE:  nxt = ST_WAIT;
            ST_WAIT:   if (expire) nxt = ST_FINISH;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        busy     = (state != ST_IDLE);
        op_start = (state == ST_ISSUE);
        run      = (state == ST_WAIT);
        finish   = (state == ST_FINISH);
    end

endmodule

// File: rtl/flcmd_top.sv
module flcmd_top
    import flcmd_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int DW         = 32,
    parameter int NWORDS     = 4,
    parameter int DIV_W      = 8,
    parameter int TICK_W     = 8,
    parameter int PROG_TICKS = 2,
    parameter int PAGE_TICKS = 3,
    parameter int MASS_TICKS = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wen,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    output logic                 irq,
    output logic                 op_start,
    output logic [1:0]           op_kind,
    output logic [DW-1:0]        op_addr,
    output logic                 op_wide,
    output logic [NWORDS*DW-1:0] op_data
);

    localparam int WI         = ADDR_W - 2;
    localparam int ALIGN_BITS = $clog2(NWORDS * DW / 8);
    localparam logic [WI-1:0] W_ADDR   = WI'(OFF_ADDR   >> 2);
    localparam logic [WI-1:0] W_CLKDIV = WI'(OFF_CLKDIV >> 2);
    localparam logic [WI-1:0] W_CTRL   = WI'(OFF_CTRL   >> 2);
    localparam logic [WI-1:0] W_INTR   = WI'(OFF_INTR   >> 2);
    localparam logic [WI-1:0] W_DATA0  = WI'(OFF_DATA0  >> 2);

    logic [WI-1:0]    widx;
    logic [DW-1:0]    addr_q;
    logic [DIV_W-1:0] div_q;
    logic [3:0]       unlock_q;
    logic [7:0]       code_q;
    logic             narrow_q;
    logic [DW-1:0]    data_q [NWORDS];
    logic             done_q, fault_q, ien_done_q, ien_fault_q;

    logic             wr_ctrl, wr_intr, wr_ok;
    logic [2:0]       starts;
    op_kind_t         req_kind;
    logic             req_ok, accept, fault_evt;
    logic [TICK_W-1:0] ticks_sel;

    seq_state_t       state;
    op_kind_t         cur_kind;
    logic             busy, run, finish, expire;

    logic unused_bits;
    assign unused_bits = ^{bus_addr[1:0], state};

    assign widx    = bus_addr[ADDR_W-1:2];
    assign wr_ok   = bus_wen && !busy;
    assign wr_ctrl = bus_wen && (widx == W_CTRL);
    assign wr_intr = bus_wen && (widx == W_INTR);
    assign starts  = bus_wdata[2:0];

    // Request screening uses the key, width and code carried by this write.
    always_comb begin
        req_kind = OP_NONE;
        req_ok   = 1'b0;
        if (starts != 3'b000 && bus_wdata[31:28] == KEY_OPEN && $countones(starts) == 1) begin
            if (starts[0]) begin
                req_kind = OP_PROG;
                req_ok   = bus_wdata[4] || (addr_q[ALIGN_BITS-1:0] == '0);
            end else if (starts[1]) begin
                req_kind = OP_MASS;
                req_ok   = (bus_wdata[15:8] == CODE_MASS);
            end else begin
                req_kind = OP_PAGE;
                req_ok   = (bus_wdata[15:8] == CODE_PAGE);
            end
        end
    end

    assign accept    = wr_ctrl && !busy && req_ok;
    assign fault_evt = wr_ctrl && (starts != 3'b000) && !accept;

    always_comb begin
        unique case (cur_kind)
            OP_PROG: ticks_sel = TICK_W'(PROG_TICKS);
            OP_PAGE: ticks_sel = TICK_W'(PAGE_TICKS);
            OP_MASS: ticks_sel = TICK_W'(MASS_TICKS);
            default: ticks_sel = TICK_W'(1);
        endcase
    end

    flcmd_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .req_kind (req_kind),
        .expire   (expire),
        .state    (state),
        .cur_kind (cur_kind),
        .busy     (busy),
        .op_start (op_start),
        .run      (run),
        .finish   (finish)
    );

    flcmd_timer #(.DIV_W(DIV_W), .TICK_W(TICK_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .divisor (div_q),
        .ticks   (ticks_sel),
        .expire  (expire)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            div_q    <= '0;
            unlock_q <= '0;
            code_q   <= '0;
            narrow_q <= 1'b0;
        end else if (wr_ok) begin
            if (widx == W_ADDR)   addr_q <= bus_wdata;
            if (widx == W_CLKDIV) div_q  <= bus_wdata[DIV_W-1:0];
            if (widx == W_CTRL) begin
                unlock_q <= bus_wdata[31:28];
                code_q   <= bus_wdata[15:8];
                narrow_q <= bus_wdata[4];
            end
        end
    end

    for (genvar g = 0; g < NWORDS; g++) begin : g_data
        always_ff @(posedge clk) begin
            if (!rst_n)
                data_q[g] <= '0;
            else if (wr_ok && widx == W_DATA0 + WI'(g))
                data_q[g] <= bus_wdata;
        end
        assign op_data[g*DW +: DW] = (g == 0 || !narrow_q) ? data_q[g] : '0;
    end

    // Flag set events take priority over a clearing write in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q      <= 1'b0;
            fault_q     <= 1'b0;
            ien_done_q  <= 1'b0;
            ien_fault_q <= 1'b0;
        end else begin
            if (finish)       done_q <= 1'b1;
            else if (wr_intr) done_q <= done_q & bus_wdata[0];
            if (fault_evt)    fault_q <= 1'b1;
            else if (wr_intr) fault_q <= fault_q & bus_wdata[1];
            if (wr_intr) begin
                ien_done_q  <= bus_wdata[8];
                ien_fault_q <= bus_wdata[9];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (widx == W_ADDR)
            bus_rdata = addr_q;
        else if (widx == W_CLKDIV)
            bus_rdata = {{(DW-DIV_W){1'b0}}, div_q};
        else if (widx == W_CTRL)
            bus_rdata = {unlock_q, 3'b000, busy, 8'h00, code_q, 3'b000, narrow_q, 1'b0,
                         cur_kind == OP_PAGE, cur_kind == OP_MASS, cur_kind == OP_PROG};
        else if (widx == W_INTR)
            bus_rdata = {22'h0, ien_fault_q, ien_done_q, 6'h00, fault_q, done_q};
        else
            for (int i = 0; i < NWORDS; i++)
                if (widx == W_DATA0 + WI'(i)) bus_rdata = data_q[i];
    end

    assign irq     = (done_q && ien_done_q) || (fault_q && ien_fault_q);
    assign op_kind = cur_kind;
    assign op_addr = addr_q;
    assign op_wide = !narrow_q;

endmodule

// File: rtl/flcmd_chk.sv
module flcmd_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         op_start,
    input logic [1:0]   op_kind,
    input logic [31:0]  op_addr,
    input logic         op_wide,
    input logic [127:0] op_data,
    input logic         busy,
    input logic         done_q,
    input logic         fault_q,
    input logic         irq
);

    assert_single_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> !op_start);

    assert_narrow_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && op_kind == 2'd1 && !op_wide) |-> (op_data[127:32] == '0));

    assert_launch_kind_R4: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> (op_kind != 2'd0));

    assert_launch_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> busy);

    assert_launch_from_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> !$past(busy));

    assert_wide_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && op_kind == 2'd1 && op_wide) |-> (op_addr[3:0] == 4'h0));

    assert_quiet_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_q && !fault_q) |-> !irq);

    assert_done_after_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> ($past(busy) && !busy));

endmodule

bind flcmd_top flcmd_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_start (op_start),
    .op_kind  (op_kind),
    .op_addr  (op_addr),
    .op_wide  (op_wide),
    .op_data  (op_data),
    .busy     (busy),
    .done_q   (done_q),
    .fault_q  (fault_q),
    .irq      (irq)
);

// File: tb/sim_flcmd_top.sv
module sim_flcmd_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [6:0]   bus_addr = '0;
    logic         bus_wen = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         irq, op_start, op_wide;
    logic [1:0]   op_kind;
    logic [31:0]  op_addr;
    logic [127:0] op_data;

    int n_checks = 0;
    int n_fails  = 0;
    int n_starts = 0;
    logic [1:0]   cap_kind;
    logic [31:0]  cap_addr;
    logic         cap_wide;
    logic [127:0] cap_data;

    always #4 clk = ~clk;

    flcmd_top #(.PROG_TICKS(2), .PAGE_TICKS(3), .MASS_TICKS(5)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .op_start(op_start), .op_kind(op_kind), .op_addr(op_addr),
        .op_wide(op_wide), .op_data(op_data)
    );

    always @(negedge clk) begin
        if (op_start) begin
            n_starts++;
            cap_kind = op_kind;
            cap_addr = op_addr;
            cap_wide = op_wide;
            cap_data = op_data;
        end
    end

    initial begin
        #(8 * 200000);
        n_fails++;
        $display("FAIL watchdog: run hung, actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bwrite(input logic [7:0] off, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = off[6:0];
        bus_wdata = d;
        bus_wen   = 1'b1;
        @(negedge clk);
        bus_wen   = 1'b0;
    endtask

    task automatic bread(input logic [7:0] off, output logic [31:0] d);
        bus_addr = off[6:0];
        #1;
        d = bus_rdata;
    endtask

    function automatic int exp_kind(input logic [3:0] unl, input logic [2:0] st,
                                    input logic nar, input logic [7:0] code,
                                    input logic [31:0] a);
        if (st == 3'b000) return -1;
        if (unl != 4'h2) return 0;
        if ($countones(st) > 1) return 0;
        if (st[0]) return (!nar && a[3:0] != 4'h0) ? 0 : 1;
        if (st[1]) return (code == 8'hAA) ? 3 : 0;
        return (code == 8'h55) ? 2 : 0;
    endfunction

    function automatic int ticks_of(input int k);
        return (k == 1) ? 2 : (k == 2) ? 3 : 5;
    endfunction

    function automatic int bit_of(input int k);
        return (k == 1) ? 0 : (k == 3) ? 1 : 2;
    endfunction

    task automatic wait_idle(output int cnt, output logic [31:0] first);
        logic [31:0] v;
        cnt = 0;
        first = '0;
        for (int i = 0; i < 2000; i++) begin
            bread(8'h08, v);
            if (i == 0) first = v;
            if (!v[24]) break;
            cnt++;
            @(negedge clk);
        end
    endtask

    task automatic run_op(input string tag, input logic [3:0] unl, input logic [2:0] st,
                          input logic nar, input logic [7:0] code, input logic [31:0] a,
                          input logic [7:0] dv, input logic [1:0] en);
        logic [31:0] d [4];
        logic [31:0] v, first;
        logic [127:0] expd;
        int k, cnt, base, nn;
        for (int i = 0; i < 4; i++) d[i] = $urandom;
        bwrite(8'h00, a);
        bwrite(8'h04, {24'h0, dv});
        for (int i = 0; i < 4; i++) bwrite(8'h30 + 8'(4 * i), d[i]);
        bwrite(8'h24, {22'h0, en[1], en[0], 8'h00});
        base = n_starts;
        bwrite(8'h08, {unl, 12'h000, code, 3'b000, nar, 1'b0, st});
        wait_idle(cnt, first);
        k  = exp_kind(unl, st, nar, code, a);
        nn = (dv == 0) ? 1 : int'(dv);
        expd = nar ? {96'h0, d[0]} : {d[3], d[2], d[1], d[0]};
        if (k > 0) begin
            check({tag, " R3 launch count"}, 128'(n_starts - base), 128'd1);
            check({tag, " R4 kind"}, 128'(cap_kind), 128'(k));
            check({tag, " R3 addr"}, 128'(cap_addr), 128'(a));
            if (k == 1) begin
                check({tag, " R3 wide"}, 128'(cap_wide), 128'(!nar));
                check({tag, " R3 data"}, cap_data, expd);
            end
            check({tag, " R5 busy cycles"}, 128'(cnt), 128'(nn * ticks_of(k) + 2));
            check({tag, " R5 request bit"}, 128'(first[bit_of(k)]), 128'd1);
        end else begin
            check({tag, " R6 no launch"}, 128'(n_starts - base), 128'd0);
            check({tag, " R9 no busy"}, 128'(cnt), 128'd0);
        end
        bread(8'h08, v);
        check({tag, " R5 bits clear"}, 128'({v[24], v[2:0]}), 128'd0);
        bread(8'h24, v);
        check({tag, " R12 done flag"}, 128'(v[0]), 128'(k > 0));
        check({tag, " R6 fault flag"}, 128'(v[1]), 128'(k == 0));
        #1;
        check({tag, " R11 irq"}, 128'(irq), 128'((v[0] && en[0]) || (v[1] && en[1])));
    endtask

    initial begin
        logic [31:0] v, first;
        int cnt, base;
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bread(8'h08, v); check("R1 ctrl", 128'(v), 128'd0);
        bread(8'h24, v); check("R1 intr", 128'(v), 128'd0);
        bread(8'h00, v); check("R1 addr", 128'(v), 128'd0);
        bread(8'h04, v); check("R1 clkdiv", 128'(v), 128'd0);
        check("R1 irq", 128'(irq), 128'd0);
        check("R1 op_start", 128'(op_start), 128'd0);

        // R2 register map
        bwrite(8'h00, 32'hA5A5_0013); bread(8'h00, v); check("R2 addr", 128'(v), 128'hA5A5_0013);
        bwrite(8'h04, 32'h0000_01FF); bread(8'h04, v); check("R2 clkdiv", 128'(v), 128'hFF);
        for (int i = 0; i < 4; i++) begin
            bwrite(8'h30 + 8'(4 * i), 32'h1111_1111 * (i + 1));
            bread(8'h30 + 8'(4 * i), v);
            check("R2 data", 128'(v), 128'(32'h1111_1111 * (i + 1)));
        end
        bwrite(8'h40, 32'hDEAD_BEEF); bread(8'h40, v); check("R2 access reads 0", 128'(v), 128'd0);
        bread(8'h10, v); check("R2 unmapped", 128'(v), 128'd0);

        // Directed corners
        run_op("R3 wide prog",   4'h2, 3'b001, 1'b0, 8'h00, 32'h0000_1230, 8'd1, 2'b01);
        run_op("R3 narrow prog", 4'h2, 3'b001, 1'b1, 8'h00, 32'h0000_1234, 8'd2, 2'b00);
        run_op("R4 page",        4'h2, 3'b100, 1'b0, 8'h55, 32'h0000_2000, 8'd0, 2'b01);
        run_op("R4 mass",        4'h2, 3'b010, 1'b0, 8'hAA, 32'h0,         8'd3, 2'b11);
        run_op("R4 bad code",    4'h2, 3'b100, 1'b0, 8'hAA, 32'h0,         8'd1, 2'b10);
        run_op("R6 locked",      4'h3, 3'b001, 1'b1, 8'h00, 32'h0,         8'd1, 2'b10);
        run_op("R8 misaligned",  4'h2, 3'b001, 1'b0, 8'h00, 32'h0000_0108, 8'd1, 2'b10);
        run_op("R9 two bits",    4'h2, 3'b011, 1'b0, 8'hAA, 32'h0,         8'd1, 2'b10);
        run_op("R9 no bits",     4'h2, 3'b000, 1'b0, 8'h55, 32'h0,         8'd1, 2'b11);

        // R7 start while busy, and writes ignored while busy
        bwrite(8'h00, 32'h0000_4000);
        bwrite(8'h04, 32'd4);
        bwrite(8'h24, 32'h0);
        base = n_starts;
        bwrite(8'h08, {4'h2, 12'h000, 8'hAA, 8'h02});
        bwrite(8'h00, 32'h0000_5670);
        bwrite(8'h04, 32'd1);
        bwrite(8'h08, {4'h2, 12'h000, 8'h00, 8'h11});
        wait_idle(cnt, first);
        check("R7 busy at retry", 128'(first[24]), 128'd1);
        check("R7 one launch", 128'(n_starts - base), 128'd1);
        bread(8'h00, v); check("R7 addr kept", 128'(v), 128'h0000_4000);
        bread(8'h04, v); check("R7 clkdiv kept", 128'(v), 128'd4);
        bread(8'h08, v); check("R7 ctrl kept", 128'(v[15:8]), 128'hAA);
        bread(8'h24, v); check("R7 fault and R12 done", 128'(v[1:0]), 128'd3);

        // R10 and R11 flag clearing and irq masking
        bwrite(8'h24, 32'h0000_0002); bread(8'h24, v); check("R10 keep fault clear done", 128'(v), 128'h2);
        #1; check("R11 masked", 128'(irq), 128'd0);
        bwrite(8'h24, 32'h0000_0202); #1; check("R11 fault enabled", 128'(irq), 128'd1);
        bwrite(8'h24, 32'h0000_0102); #1; check("R11 only done enabled", 128'(irq), 128'd0);
        bwrite(8'h24, 32'h0000_0300); bread(8'h24, v); check("R10 cleared", 128'(v), 128'h300);
        #1; check("R11 cleared irq", 128'(irq), 128'd0);

        // Constrained random operations
        for (int it = 0; it < 40; it++) begin
            logic [3:0] unl;
            logic [2:0] st;
            logic [7:0] code;
            logic [31:0] a;
            int r;
            unl = ($urandom % 5 == 0) ? 4'($urandom) : 4'h2;
            r = $urandom % 8;
            st = (r < 3) ? 3'b001 : (r < 5) ? 3'b010 : (r < 7) ? 3'b100 : 3'($urandom);
            code = ($urandom % 4 == 0) ? 8'($urandom) : (st[1] ? 8'hAA : 8'h55);
            a = $urandom;
            if ($urandom % 4 != 0) a[3:0] = 4'h0;
            run_op("R5 random", unl, st, 1'($urandom), code, a, 8'($urandom % 4), 2'($urandom));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule